// File: doc/BRIEF.md
# Serial LED Status Shifter

This block drives a remote 32-bit shift register over two wires, a gated serial clock and a data line, so that a bank of status LEDs can show per-port activity, how full the packet buffer is, and two alarm conditions. It builds one 32-bit status word out of the per-port activity inputs, a thermometer code derived from a buffer utilization percentage, a buffer almost-full flag and a memory self-test failure flag. It sends that word as a burst of exactly 32 clock pulses. After each burst the clock stays low until the next one.

The serial bit time (320 ns by default) and the spacing between burst starts (655 µs by default) are given in nanoseconds. Together with the system clock frequency they set the cycle counts. The word is sampled once, on the cycle before a burst begins, so an input that changes during a burst has no effect until the next burst. Data changes only on the falling serial clock edge, which leaves it stable around each rising edge where the receiver latches it.

Top module: `led_status_serializer`

## Requirements
- R1: Every burst has exactly 32 rising edges of `led_clk_o`. Between bursts `led_clk_o` stays low.
- R2: Within a burst, each serial bit lasts 2*HALF system cycles, where HALF = (CLK_FREQ_HZ/1e6)*SCLK_NS/2000. `led_clk_o` is low for the first HALF cycles of each bit and high for the last HALF cycles.
- R3: Consecutive bursts start exactly FRAME = (CLK_FREQ_HZ/1e6)*FRAME_NS/1000 system cycles apart. The first burst starts on the first clock edge after reset is released.
- R4: Word bit i, for i from 0 to 15, carries `port_act_i[i]`.
- R5: Word bit 16+k is 1 exactly when `util_pct_i` is at least the k-th threshold. The thresholds, for k from 0 to 13, are 1, 3, 5, 10, 15, 20, 30, 35, 40, 50, 60, 70, 80 and 90 percent.
- R6: Word bit 30 carries `buf_alarm_i` and word bit 31 carries `mem_fail_i`.
- R7: Word bit 0 is sent first and bit 31 last. One bit is sent per serial clock pulse.
- R8: The word is sampled on the system cycle just before a burst starts. Input changes during a burst do not change the bits of that burst.
- R9: `led_data_o` changes only where `led_clk_o` falls or at the start of a burst. It holds steady while `led_clk_o` is high, and it is low between bursts.
- R10: While `rst_ni` is low, `led_clk_o` and `led_data_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_act_i | input | 16 | Per-port link/receive activity |
| util_pct_i | input | 7 | Packet buffer utilization in percent |
| buf_alarm_i | input | 1 | Buffer almost-full alarm |
| mem_fail_i | input | 1 | External memory self-test failure |
| led_clk_o | output | 1 | Gated serial clock to the external shift register |
| led_data_o | output | 1 | Serial status data |

## Verification
Errors in the frame or bit counters appear on `led_clk_o`. A wrong bit counter shows up in the same burst as a pulse count other than 32. A wrong frame counter shows up at the next burst start as the wrong spacing between bursts. Errors in the shift register or in word assembly appear on `led_data_o` at the rising clock edge for the affected bit. The per-cycle reference model and the reassembled word therefore catch them within one burst, and they point to the field at fault. A word sampled at the wrong time is exposed because the stimulus changes the inputs in the middle of every burst.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  localparam int NUM_THR = 14;

  // utilization thresholds in percent, ascending
  function automatic int thr_pct(input int k);
    case (k)
      0:  return 1;
      1:  return 3;
      2:  return 5;
      3:  return 10;
      4:  return 15;
      5:  return 20;
      6:  return 30;
      7:  return 35;
      8:  return 40;
      9:  return 50;
      10: return 60;
      11: return 70;
      12: return 80;
      13: return 90;
      default: return 1000;
    endcase
  endfunction
endpackage

// File: rtl/led_util_therm.sv
module led_util_therm
  import led_ser_pkg::*;
#(
  parameter int UTIL_W = 7
) (
  input  logic [UTIL_W-1:0]  util_i,
  output logic [NUM_THR-1:0] therm_o
);
  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    assign therm_o[k] = (int'(util_i) >= thr_pct(k));
  end
endmodule

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int SCLK_NS     = 320,
  parameter int FRAME_NS    = 655_000,
  parameter int NBITS       = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic shift_o,
  output logic burst_o,
  output logic sclk_o
);
  localparam int CYC_US = CLK_FREQ_HZ / 1_000_000;
  localparam int HALF   = CYC_US * SCLK_NS / 2000;
  localparam int PERIOD = 2 * HALF;
  localparam int FRAME  = CYC_US * FRAME_NS / 1000;
  localparam int FW     = $clog2(FRAME);
  localparam int PW     = $clog2(PERIOD + 1);
  localparam int BW     = $clog2(NBITS);

  logic [FW-1:0] fcnt_q;
  logic [PW-1:0] pcnt_q;
  logic [BW-1:0] bcnt_q;
  logic          act_q;

  logic frame_end, bit_end;
  assign frame_end = (fcnt_q == FW'(FRAME - 1));
  assign bit_end   = act_q && (pcnt_q == PW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= FW'(FRAME - 1);
      pcnt_q <= '0;
      bcnt_q <= '0;
      act_q  <= 1'b0;
    end else if (frame_end) begin
      fcnt_q <= '0;
      pcnt_q <= '0;
      bcnt_q <= '0;
      act_q  <= 1'b1;
    end else begin
      fcnt_q <= fcnt_q + 1'b1;
      if (act_q) begin
        if (bit_end) begin
          pcnt_q <= '0;
          if (bcnt_q == BW'(NBITS - 1)) act_q <= 1'b0;
          else bcnt_q <= bcnt_q + 1'b1;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  assign load_o  = frame_end;
  assign shift_o = bit_end;
  assign burst_o = act_q;
  assign sclk_o  = act_q && (pcnt_q >= PW'(HALF));

  // sampling point must fall inside the idle gap
  p_load_in_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> !burst_o && !sclk_o);
endmodule

// File: rtl/led_shift_engine.sv
module led_shift_engine #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              burst_i,
  input  logic              sclk_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              data_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  assign data_o = burst_i & sh_q[0];

  // shifting lands on the falling serial edge
  p_shift_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> $fell(sclk_i));
endmodule

// File: rtl/led_status_serializer.sv
module led_status_serializer
  import led_ser_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int SCLK_NS     = 320,
  parameter int FRAME_NS    = 655_000,
  parameter int NUM_PORTS   = 16,
  parameter int UTIL_W      = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] port_act_i,
  input  logic [UTIL_W-1:0]    util_pct_i,
  input  logic                 buf_alarm_i,
  input  logic                 mem_fail_i,
  output logic                 led_clk_o,
  output logic                 led_data_o
);
  localparam int WORD_W = NUM_PORTS + NUM_THR + 2;
  localparam int CW     = $clog2(WORD_W + 2);

  logic               load, shift, burst;
  logic [NUM_THR-1:0] therm;
  logic [WORD_W-1:0]  word;

  led_util_therm #(.UTIL_W(UTIL_W)) u_therm (
    .util_i (util_pct_i),
    .therm_o(therm)
  );

  led_timebase #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .SCLK_NS    (SCLK_NS),
    .FRAME_NS   (FRAME_NS),
    .NBITS      (WORD_W)
  ) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_o (load),
    .shift_o(shift),
    .burst_o(burst),
    .sclk_o (led_clk_o)
  );

  assign word = {mem_fail_i, buf_alarm_i, therm, port_act_i};

  led_shift_engine #(.WORD_W(WORD_W)) u_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .burst_i(burst),
    .sclk_i (led_clk_o),
    .word_i (word),
    .data_o (led_data_o)
  );

  // pulse counter used only by the checks below
  logic [CW-1:0] rise_cnt_q;
  logic          sclk_d_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt_q <= '0;
      sclk_d_q   <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      sclk_d_q <= led_clk_o;
      if (load) begin
        rise_cnt_q <= '0;
        seen_q     <= 1'b1;
      end else if (led_clk_o && !sclk_d_q) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  p_pulse_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (!seen_q || rise_cnt_q == CW'(WORD_W)));

  p_data_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_clk_o && $past(led_clk_o)) |-> $stable(led_data_o));

  p_reset_idle_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!led_clk_o && !led_data_o));
endmodule

// File: tb/sim_led_status_serializer.sv
`timescale 1ns/1ps
module sim_led_status_serializer;
  localparam int HALF  = 4;     // 200 MHz, 40 ns bit
  localparam int FRAME = 1600;  // 8000 ns
  localparam int BURST = 64 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] act = '0;
  logic [6:0]  util = '0;
  logic        ba = 1'b0, mf = 1'b0;
  logic        sclk, sdat;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  led_status_serializer #(
    .CLK_FREQ_HZ(200_000_000), .SCLK_NS(40), .FRAME_NS(8000)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_act_i(act), .util_pct_i(util),
    .buf_alarm_i(ba), .mem_fail_i(mf), .led_clk_o(sclk), .led_data_o(sdat)
  );

  int thr [14] = '{1, 3, 5, 10, 15, 20, 30, 35, 40, 50, 60, 70, 80, 90};

  function automatic logic [13:0] therm_of(input int u);
    logic [13:0] t = '0;
    for (int k = 0; k < 14; k++) if (u >= thr[k]) t[k] = 1'b1;
    return t;
  endfunction

  // behavioural reference: frame position and captured word
  int          mt = FRAME - 1;
  logic [31:0] mword = '0;
  always @(posedge clk) begin
    if (!rst_n) mt = FRAME - 1;
    else if (mt == FRAME - 1) begin
      mt    = 0;
      mword = {mf, ba, therm_of(int'(util)), act};
    end else mt = mt + 1;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // per-cycle compare plus receiver
  logic        prev_sclk = 1'b0;
  int          rx_n = 0, rises = 0, last_start = -1;
  logic [31:0] rx = '0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      report();
    end
    if (!rst_n) begin
      vectors++;
      if (sclk !== 1'b0 || sdat !== 1'b0) begin
        fails++;
        $display("FAIL R10 reset: actual clk=%b data=%b expected 0 0", sclk, sdat);
      end
    end else if (!done) begin
      logic exp_c, exp_d;
      exp_c = (mt < BURST) && ((mt % (2 * HALF)) >= HALF);
      exp_d = (mt < BURST) ? mword[mt / (2 * HALF)] : 1'b0;
      vectors++;
      if (sclk !== exp_c) begin
        fails++;
        $display("FAIL R2 clk at pos %0d: actual %b expected %b", mt, sclk, exp_c);
      end
      if (sdat !== exp_d) begin
        fails++;
        $display("FAIL R9 data at pos %0d: actual %b expected %b", mt, sdat, exp_d);
      end
      if (sclk && !prev_sclk) begin
        if (rx_n == 0) begin
          if (last_start >= 0) begin
            vectors++;
            if (cyc - last_start != FRAME) begin
              fails++;
              $display("FAIL R3 spacing: actual %0d expected %0d", cyc - last_start, FRAME);
            end
          end
          last_start = cyc;
        end
        rx[rx_n] = sdat;
        rx_n++;
        rises++;
        if (rx_n == 32) begin
          rx_n = 0;
          vectors++;
          if (rx[15:0] !== mword[15:0]) begin
            fails++;
            $display("FAIL R4 ports: actual %h expected %h", rx[15:0], mword[15:0]);
          end
          vectors++;
          if (rx[29:16] !== mword[29:16]) begin
            fails++;
            $display("FAIL R5 therm: actual %b expected %b", rx[29:16], mword[29:16]);
          end
          vectors++;
          if (rx[31:30] !== mword[31:30]) begin
            fails++;
            $display("FAIL R6 alarms: actual %b expected %b", rx[31:30], mword[31:30]);
          end
          // inputs change mid-burst, so the word must match the sample (R7, R8)
          vectors++;
          if (rx !== mword) begin
            fails++;
            $display("FAIL R8 word: actual %h expected %h", rx, mword);
          end
        end
      end
      if (mt == BURST + 2) begin
        vectors++;
        if (rises != 32) begin
          fails++;
          $display("FAIL R1 pulses: actual %0d expected 32", rises);
        end
        rises = 0;
      end
    end
    prev_sclk = sclk;
  end

  logic [15:0] p_act  [10] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0001, 16'h8000,
                              16'h5A5A, 16'h1234, 16'hFFFE, 16'h0F0F, 16'hC3A5};
  int          p_util [10] = '{0, 100, 3, 2, 90, 89, 10, 1, 50, 127};
  logic        p_ba   [10] = '{0, 1, 0, 1, 0, 1, 1, 0, 0, 1};
  logic        p_mf   [10] = '{0, 1, 1, 0, 0, 0, 1, 0, 1, 0};

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 1; p < 10; p++) begin
      @(negedge clk);
      while (mt != 100) @(negedge clk);
      act  = p_act[p];
      util = 7'(p_util[p]);
      ba   = p_ba[p];
      mf   = p_mf[p];
    end
    repeat (2 * FRAME) @(negedge clk);
    done = 1;
    report();
  end
endmodule